// File: doc/BRIEF.md
# Per-Area Bus Cycle Wait Controller

This block times the external bus cycles issued by a single-address DMA transfer engine. For each transfer it takes the target area number (eight areas), the kind of space being addressed, the direction, and a small long-wait setting. From these it decides how many bus states the cycle lasts. A 16-bit configuration register holds one WAIT-sampling enable per area for reads and one per area for writes. When an enable is set, the external WAIT input can stretch the cycle one state at a time.

A request is offered with `req_valid` and the fields beside it. The handshake completes on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is high only while the controller is idle, so a request offered during a cycle is held off and is not queued. Back-pressure therefore lasts from the accept edge until the edge that ends the final state. During the cycle the controller drives per-state strobes: first state, long-wait state and WAIT-inserted state. It also drives `busy`, and it pulses `cyc_done` for one clock in the final state.

Top module: `bus_wait_ctrl`

## Requirements
- R1: The configuration register `cfg_wdata`/`cfg_we` is loaded on a rising edge with `cfg_we` high. Bits 15..8 are the read-cycle enables for areas 7..0, and bits 7..0 are the write-cycle enables for areas 7..0. After reset every bit is 1, so every area samples WAIT in both directions.
- R2: An enable of 0 makes the controller ignore WAIT for that area and direction. An enable of 1 makes it sample WAIT. A read takes its enable from the read byte and a write takes its enable from the write byte.
- R3: Space codes: `req_space` 0 is normal memory, 1 is DRAM, 2 is multiplexed address/data I/O, and 3 behaves as normal memory. In normal memory, areas 1, 3, 4, 5 and 7 last exactly 1 state with sampling disabled. With sampling enabled they last 2 states plus the WAIT-inserted states.
- R4: In normal memory, areas 0, 2 and 6 last 1 state plus `req_long`+1 long-wait states. When sampling is enabled, WAIT-inserted states follow those.
- R5: In DRAM space a cycle lasts 1 state with sampling disabled. With sampling enabled it lasts 2 states plus the WAIT-inserted states.
- R6: In multiplexed I/O space a cycle lasts 4 states plus the WAIT-inserted states, and WAIT is sampled whatever the enable bit holds.
- R7: WAIT is first sampled at the rising edge that ends the last base state. Each sample seen high inserts one more state, and the first sample seen low ends the cycle. WAIT high during earlier base states has no effect.
- R8: `cyc_done` is high for exactly one clock, in the final state of the cycle. `busy` is low on the following clock.
- R9: `req_ready` equals not `busy`. A request is accepted only on an edge where the controller is idle, and the cycle's first state follows the accept edge at once. A request held during a cycle does not start a cycle at the edge that ends it.
- R10: `st_first` is high in the first state of every cycle. `st_long` is high in each long-wait state of areas 0, 2 and 6. `st_wait` is high in each WAIT-inserted state. At most one of the three is high in any clock.
- R11: A synchronous active-low reset returns the controller to idle in the next clock, even in the middle of a cycle, and loads every enable bit as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the enable register |
| cfg_wdata | input | 16 | Enable register value (read byte high, write byte low) |
| req_valid | input | 1 | Cycle request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_area | input | 3 | Target area number |
| req_space | input | 2 | Space type code |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| req_long | input | 2 | Long-wait setting, gives 1 to 4 extra states |
| wait_in | input | 1 | External WAIT, active high |
| busy | output | 1 | A bus cycle is in progress |
| st_first | output | 1 | First state of the cycle |
| st_long | output | 1 | Long-wait state |
| st_wait | output | 1 | WAIT-inserted state |
| cyc_done | output | 1 | Final state of the cycle |

## Verification
A wrong latched length or sampling enable shows up within the same cycle as a `cyc_done` that comes early or late. Because the bench counts states from the accept edge, the error appears within at most a few clocks. A phase register that is stuck or leaks appears on the next clock as `busy` staying high after `cyc_done`, or as `req_ready` disagreeing with `busy`. An enable bit taken from the wrong byte or area appears only when a cycle targets that area and direction. For that reason, random requests run against several register patterns, with WAIT held high across the early base states.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [1:0] {
    SP_NORMAL = 2'd0,
    SP_DRAM   = 2'd1,
    SP_MUXIO  = 2'd2,
    SP_ALT    = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BASE = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg #(
  parameter int N_AREAS = 8,
  parameter int AREA_W  = $clog2(N_AREAS),
  localparam int CFG_W  = 2 * N_AREAS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [AREA_W-1:0] sel_area,
  input  logic              sel_write,
  output logic              samp_bit
);

  logic [CFG_W-1:0]   cfg_q;
  logic [N_AREAS-1:0] rd_en_vec;
  logic [N_AREAS-1:0] wr_en_vec;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '1;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // upper half: read enables, lower half: write enables, area i at offset i
  for (genvar i = 0; i < N_AREAS; i++) begin : g_split
    assign rd_en_vec[i] = cfg_q[N_AREAS + i];
    assign wr_en_vec[i] = cfg_q[i];
  end

  always_comb begin
    samp_bit = sel_write ? wr_en_vec[sel_area] : rd_en_vec[sel_area];
  end

endmodule

// File: rtl/bwc_len_calc.sv
module bwc_len_calc
  import bwc_pkg::*;
#(
  parameter int                   N_AREAS        = 8,
  parameter int                   AREA_W         = $clog2(N_AREAS),
  parameter int                   LONG_W         = 2,
  parameter int                   MUX_BASE       = 4,
  parameter int                   CNT_W          = 3,
  parameter logic [N_AREAS-1:0]   LONG_AREA_MASK = 8'b0100_0101
) (
  input  logic [AREA_W-1:0] area,
  input  logic [1:0]        space,
  input  logic [LONG_W-1:0] long_sel,
  input  logic              samp_bit,
  output logic [CNT_W-1:0]  base_len,
  output logic              samp_en,
  output logic              long_cyc
);

  logic long_group;
  assign long_group = LONG_AREA_MASK[area];

  always_comb begin
    base_len = CNT_W'(1);
    samp_en  = 1'b0;
    long_cyc = 1'b0;
    unique case (space_e'(space))
      SP_DRAM: begin
        base_len = samp_bit ? CNT_W'(2) : CNT_W'(1);
        samp_en  = samp_bit;
      end
      SP_MUXIO: begin
        base_len = CNT_W'(MUX_BASE);
        samp_en  = 1'b1;
      end
      default: begin
        if (long_group) begin
          // one leading state plus long_sel+1 long-wait states
          base_len = CNT_W'(2) + CNT_W'(long_sel);
          samp_en  = samp_bit;
          long_cyc = 1'b1;
        end else begin
          base_len = samp_bit ? CNT_W'(2) : CNT_W'(1);
          samp_en  = samp_bit;
        end
      end
    endcase
  end

endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
  import bwc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] base_len,
  input  logic             samp_en,
  input  logic             long_cyc,
  input  logic             wait_in,
  output logic             busy,
  output logic             st_first,
  output logic             st_long,
  output logic             st_wait,
  output logic             cyc_done
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             samp_q;
  logic             long_q;
  logic             accept;
  logic             last_base;
  logic             stretch;

  assign accept    = req_valid && (phase_q == PH_IDLE);
  assign last_base = (phase_q == PH_BASE) && (cnt_q == len_q);
  assign stretch   = samp_q && wait_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      samp_q  <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_BASE;
            cnt_q   <= CNT_W'(1);
            len_q   <= base_len;
            samp_q  <= samp_en;
            long_q  <= long_cyc;
          end
        end
        PH_BASE: begin
          if (last_base) phase_q <= stretch ? PH_WAIT : PH_IDLE;
          else           cnt_q   <= cnt_q + CNT_W'(1);
        end
        PH_WAIT: begin
          if (!wait_in) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (phase_q == PH_IDLE);
    busy      = (phase_q != PH_IDLE);
    st_first  = (phase_q == PH_BASE) && (cnt_q == CNT_W'(1));
    st_long   = (phase_q == PH_BASE) && long_q && (cnt_q != CNT_W'(1));
    st_wait   = (phase_q == PH_WAIT);
    cyc_done  = (last_base && !stretch) || ((phase_q == PH_WAIT) && !wait_in);
  end

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int                 N_AREAS        = 8,
  parameter int                 AREA_W         = $clog2(N_AREAS),
  parameter int                 LONG_W         = 2,
  parameter int                 MUX_BASE       = 4,
  parameter logic [N_AREAS-1:0] LONG_AREA_MASK = 8'b0100_0101
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2*N_AREAS-1:0]   cfg_wdata,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AREA_W-1:0]      req_area,
  input  logic [1:0]             req_space,
  input  logic                   req_write,
  input  logic [LONG_W-1:0]      req_long,
  input  logic                   wait_in,
  output logic                   busy,
  output logic                   st_first,
  output logic                   st_long,
  output logic                   st_wait,
  output logic                   cyc_done
);

  localparam int MAX_BASE = max_u(MUX_BASE, 1 + (1 << LONG_W));
  localparam int CNT_W    = $clog2(MAX_BASE + 1);

  logic             samp_bit;
  logic [CNT_W-1:0] base_len;
  logic             samp_en;
  logic             long_cyc;

  bwc_cfg_reg #(
    .N_AREAS (N_AREAS),
    .AREA_W  (AREA_W)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sel_area  (req_area),
    .sel_write (req_write),
    .samp_bit  (samp_bit)
  );

  bwc_len_calc #(
    .N_AREAS        (N_AREAS),
    .AREA_W         (AREA_W),
    .LONG_W         (LONG_W),
    .MUX_BASE       (MUX_BASE),
    .CNT_W          (CNT_W),
    .LONG_AREA_MASK (LONG_AREA_MASK)
  ) len_i (
    .area     (req_area),
    .space    (req_space),
    .long_sel (req_long),
    .samp_bit (samp_bit),
    .base_len (base_len),
    .samp_en  (samp_en),
    .long_cyc (long_cyc)
  );

  bwc_seq #(
    .CNT_W (CNT_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .base_len  (base_len),
    .samp_en   (samp_en),
    .long_cyc  (long_cyc),
    .wait_in   (wait_in),
    .busy      (busy),
    .st_first  (st_first),
    .st_long   (st_long),
    .st_wait   (st_wait),
    .cyc_done  (cyc_done)
  );

endmodule

// File: rtl/bwc_chk.sv
module bwc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic st_first,
  input logic st_long,
  input logic st_wait,
  input logic cyc_done
);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy);

  p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && st_first));

  p_done_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> busy);

  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !busy);

  p_first_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> st_first);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_first, st_long, st_wait}));

  p_wait_after_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_wait |-> $past(busy));

endmodule

bind bus_wait_ctrl bwc_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .st_first  (st_first),
  .st_long   (st_long),
  .st_wait   (st_wait),
  .cyc_done  (cyc_done)
);

// File: tb/bus_wait_ctrl_tb_top.sv
module bus_wait_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_area = '0;
  logic [1:0]  req_space = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_long = '0;
  logic        wait_in = 1'b0;
  logic        busy, st_first, st_long, st_wait, cyc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] cfg_m = 16'hFFFF;

  always #2 clk = ~clk;

  bus_wait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
    .req_space(req_space), .req_write(req_write), .req_long(req_long),
    .wait_in(wait_in), .busy(busy), .st_first(st_first), .st_long(st_long),
    .st_wait(st_wait), .cyc_done(cyc_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_long_area(input int a);
    return (a == 0) || (a == 2) || (a == 6);
  endfunction

  function automatic bit exp_samp(input int a, input int sp, input bit wr);
    if (sp == 2) return 1'b1;
    return wr ? cfg_m[a] : cfg_m[8 + a];
  endfunction

  function automatic int exp_base(input int a, input int sp, input bit wr, input int lng);
    bit en = exp_samp(a, sp, wr);
    if (sp == 2) return 4;
    if (sp != 1 && is_long_area(a)) return 2 + lng;
    return en ? 2 : 1;
  endfunction

  function automatic string tag_of(input int a, input int sp);
    if (sp == 1) return "R5";
    if (sp == 2) return "R6";
    return is_long_area(a) ? "R4" : "R3";
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_m = v;
  endtask

  // run one cycle; WAIT is high for states 1..base+k-1, so k states are inserted when sampled
  task automatic run_cycle(input int a, input int sp, input bit wr, input int lng,
                           input int k, input bit hold);
    int base = exp_base(a, sp, wr, lng);
    bit en   = exp_samp(a, sp, wr);
    int exp_len = base + (en ? k : 0);
    int exp_longs = (sp != 1 && sp != 2 && is_long_area(a)) ? lng + 1 : 0;
    int done_n = 0;
    int waits = 0;
    int longs = 0;
    int firsts = 0;
    @(negedge clk);
    req_area = 3'(a); req_space = 2'(sp); req_write = wr; req_long = 2'(lng);
    req_valid = 1'b1; wait_in = 1'b0;
    #1 check("R9 ready when idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = hold;
    for (int n = 1; n <= 40; n++) begin
      wait_in = (n <= base + k - 1);
      #1;
      if (busy !== 1'b1) begin
        check("R9 busy during cycle", int'(busy), 1);
        break;
      end
      if (st_first) firsts++;
      if (n == 1) check("R10 first strobe", int'(st_first), 1);
      if (st_wait) waits++;
      if (st_long) longs++;
      if (cyc_done) begin done_n = n; break; end
      @(negedge clk);
    end
    check({tag_of(a, sp), " R2 R7 cycle length"}, done_n, exp_len);
    check("R10 wait strobes", waits, exp_len - base);
    check("R10 long strobes", longs, exp_longs);
    check("R10 single first", firsts, 1);
    @(negedge clk);
    req_valid = 1'b0; wait_in = 1'b0;
    #1 check("R8 idle after done", int'(busy), 0);
    if (hold) check("R9 held request not queued", int'(req_ready), 1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1 check("R11 reset idle", int'(busy), 0);
    check("R11 reset done low", int'(cyc_done), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value samples everywhere, both directions
    run_cycle(1, 0, 0, 0, 2, 0);
    run_cycle(7, 0, 1, 0, 1, 0);
    run_cycle(2, 0, 0, 1, 2, 0);
    run_cycle(5, 1, 1, 0, 3, 0);

    // R2: all enables cleared, WAIT ignored except in multiplexed I/O
    write_cfg(16'h0000);
    run_cycle(3, 0, 0, 0, 3, 0);
    run_cycle(0, 0, 1, 3, 2, 1);
    run_cycle(4, 1, 0, 0, 2, 0);
    run_cycle(6, 2, 1, 0, 3, 0);
    run_cycle(4, 3, 0, 0, 2, 0);

    // R1 byte split: read byte for area 5 only, write byte for area 1 only
    write_cfg(16'h2002);
    run_cycle(5, 0, 0, 0, 1, 0);
    run_cycle(5, 0, 1, 0, 1, 0);
    run_cycle(1, 0, 1, 0, 2, 0);
    run_cycle(1, 0, 0, 0, 2, 0);

    // random mix
    for (int i = 0; i < 120; i++) begin
      if (i % 30 == 0) write_cfg(16'($urandom));
      run_cycle(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                1'($urandom), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 4)), 1'($urandom));
    end

    // R11: reset mid-cycle
    write_cfg(16'h0000);
    @(negedge clk);
    req_area = 3'd0; req_space = 2'd2; req_write = 1'b0; req_valid = 1'b1; wait_in = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1 check("R11 mid-cycle reset idle", int'(busy), 0);
    check("R11 ready after reset", int'(req_ready), 1);
    rst_n = 1'b1; wait_in = 1'b0;
    cfg_m = 16'hFFFF;
    run_cycle(3, 0, 1, 0, 1, 0);
    run_cycle(6, 0, 0, 0, 1, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule